// File: doc/BRIEF.md
# Push-Button and Power-Fail Reset Sequencer

This block drives an active-low reset line for a processor from two sources. The first is a mechanical push-button, which reaches the block as an asynchronous active-low level. The second is an active-high power-fail flag from an external supply comparator, already synchronous to the block's clock. Every interval is a parameter counted in cycles of the one clock.

The button level passes through a two-stage synchronizer and a debounce filter. A falling edge of the filtered level, seen while the block is idle, starts a reset cycle. Reset stays asserted for at least one stretch window and for as long as the button is held. It then stays asserted for one more full window after the filtered release.

The power-fail flag overrides everything. While it is high, reset is held. When it falls, one stretch window runs before reset is released. The block's own reset leaves the output asserted and runs one stretch window before release.

Top module: `pbrst_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is low. After `rst_ni` rises, `rst_no` stays low and goes high on the STRETCH_CYCLES-th rising clock edge, provided no power-fail occurs.
- R2: A falling edge on `btn_ni` that stays low drives `rst_no` low on the (DEBOUNCE_CYCLES+3)-th rising edge after the input falls. This delay is two synchronizer stages, DEBOUNCE_CYCLES filter cycles and one sequencer cycle.
- R3: Once a button press asserts reset, `rst_no` stays low for at least STRETCH_CYCLES cycles.
- R4: While the filtered button level stays low, `rst_no` stays low for as long as the press lasts.
- R5: After a long press, `rst_no` goes high on the (DEBOUNCE_CYCLES+STRETCH_CYCLES+3)-th rising edge after `btn_ni` rises.
- R6: A press that is released before its first stretch window ends keeps `rst_no` low for exactly 2*STRETCH_CYCLES+1 cycles. That is the first window, one cycle to see the release, then a full window.
- R7: A button falling edge that occurs while a reset cycle is in progress is discarded. A button still held when that cycle ends does not start a new reset.
- R8: On the rising edge after `pwr_fail_i` is sampled high, `rst_no` is low, and it stays low while `pwr_fail_i` stays high.
- R9: After `pwr_fail_i` falls, `rst_no` goes high on the (STRETCH_CYCLES+1)-th rising edge, provided the flag stays low.
- R10: A power-fail during a button cycle takes over. Release timing then follows R9 from the fall of `pwr_fail_i`, whatever the button does.
- R11: A low pulse on `btn_ni` lasting fewer than DEBOUNCE_CYCLES clock cycles never asserts reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| btn_ni | input | 1 | Push-button level, active low, asynchronous |
| pwr_fail_i | input | 1 | Synchronous supply out-of-tolerance flag, active high |
| rst_no | output | 1 | Registered active-low reset to the processor |

## Verification
On every cycle, the assertions check these properties:
- the power-fail override reaches the output one cycle later;
- the output only rises on the cycle that closes a stretch window;
- the stretch counter stays inside its window;
- the filtered button level only moves toward the synchronized value;
- reset stays asserted while a held button is being waited on.

Absolute latencies need the bench's timed scenarios. These cover the power-on window, the press and release delays, the 2*STRETCH_CYCLES+1 length of a short press, glitch rejection, and the discarding of edges that arrive during a power-fail cycle.

// File: rtl/pbrst_pkg.sv
package pbrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESS,
    ST_HOLD,
    ST_RELEASE,
    ST_PF_HOLD,
    ST_PF_STRETCH
  } rst_state_e;

  // True on the last cycle of a window of span cycles counted from zero.
  function automatic logic window_end(input int unsigned count, input int unsigned span);
    return count == span - 1;
  endfunction

endpackage

// File: rtl/pbrst_sync.sv
module pbrst_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= {STAGES{RESET_VAL}};
    else         shift_q <= {shift_q[STAGES-2:0], d_i};
  end

  assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/pbrst_debounce.sv
module pbrst_debounce #(
  parameter int unsigned DEBOUNCE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned DW = $clog2(DEBOUNCE_CYCLES + 1);

  logic [DW-1:0] cnt_q;
  logic          level_q;
  logic          fall_q;
  logic          settle;

  assign settle = (raw_i != level_q) && pbrst_pkg::window_end(32'(cnt_q), DEBOUNCE_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      fall_q <= settle && !raw_i;
      if (raw_i == level_q) begin
        cnt_q <= '0;
      end else if (settle) begin
        level_q <= raw_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/pbrst_seq.sv
module pbrst_seq
  import pbrst_pkg::*;
#(
  parameter int unsigned STRETCH_CYCLES = 1000,
  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          press_i,
  input  logic          btn_level_i,
  input  logic          pwr_fail_i,
  output logic          rst_no,
  output rst_state_e    state_o,
  output logic          stretch_end_o,
  output logic [CW-1:0] count_o
);
  rst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_stretch, stretch_end;
  logic          rst_q;

  assign in_stretch  = state_q inside {ST_PRESS, ST_RELEASE, ST_PF_STRETCH};
  assign stretch_end = in_stretch && window_end(32'(cnt_q), STRETCH_CYCLES);

  always_comb begin
    state_d = state_q;
    cnt_d   = (in_stretch && !stretch_end) ? cnt_q + 1'b1 : '0;
    unique case (state_q)
      ST_IDLE:       if (press_i)      state_d = ST_PRESS;
      ST_PRESS:      if (stretch_end)  state_d = ST_HOLD;
      ST_HOLD:       if (btn_level_i)  state_d = ST_RELEASE;
      ST_RELEASE:    if (stretch_end)  state_d = ST_IDLE;
      ST_PF_HOLD:    if (!pwr_fail_i)  state_d = ST_PF_STRETCH;
      ST_PF_STRETCH: if (stretch_end)  state_d = ST_IDLE;
      default:                         state_d = ST_PF_HOLD;
    endcase
    if (pwr_fail_i) begin
      state_d = ST_PF_HOLD;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PF_STRETCH;
      cnt_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rst_q   <= (state_d == ST_IDLE);
    end
  end

  assign rst_no        = rst_q;
  assign state_o       = state_q;
  assign stretch_end_o = stretch_end;
  assign count_o       = cnt_q;
endmodule

// File: rtl/pbrst_ctrl.sv
module pbrst_ctrl #(
  parameter int unsigned DEBOUNCE_CYCLES = 16,
  parameter int unsigned STRETCH_CYCLES  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic pwr_fail_i,
  output logic rst_no
);
  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1);

  logic                  btn_sync_w;
  logic                  btn_level_w;
  logic                  press_w;
  logic                  stretch_end_w;
  logic [CW-1:0]         count_w;
  pbrst_pkg::rst_state_e state_w;

  pbrst_sync #(.STAGES(2), .RESET_VAL(1'b1)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ni),
    .q_o   (btn_sync_w)
  );

  pbrst_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) deb_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (btn_sync_w),
    .level_o(btn_level_w),
    .fall_o (press_w)
  );

  pbrst_seq #(.STRETCH_CYCLES(STRETCH_CYCLES)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .press_i      (press_w),
    .btn_level_i  (btn_level_w),
    .pwr_fail_i   (pwr_fail_i),
    .rst_no       (rst_no),
    .state_o      (state_w),
    .stretch_end_o(stretch_end_w),
    .count_o      (count_w)
  );
endmodule

// File: rtl/pbrst_ctrl_chk.sv
module pbrst_ctrl_chk #(
  parameter int unsigned STRETCH_CYCLES = 1000,
  localparam int unsigned CW = $clog2(STRETCH_CYCLES + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pwr_fail_i,
  input logic                  rst_no,
  input logic                  btn_sync,
  input logic                  btn_level,
  input logic                  stretch_end,
  input logic [CW-1:0]         count,
  input pbrst_pkg::rst_state_e state
);
  // R1
  reset_held_in_reset_chk: assert property (@(posedge clk_i) !rst_ni |-> !rst_no);

  // R8
  pf_forces_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !rst_no);

  // R9
  release_at_window_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(stretch_end) && !$past(pwr_fail_i));

  // R3
  count_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count) < STRETCH_CYCLES);

  // R11
  level_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(btn_level) |-> $past(btn_sync) == btn_level);

  // R4
  hold_keeps_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == pbrst_pkg::ST_HOLD && !btn_level) |=> !rst_no);
endmodule

bind pbrst_ctrl pbrst_ctrl_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_fail_i (pwr_fail_i),
  .rst_no     (rst_no),
  .btn_sync   (btn_sync_w),
  .btn_level  (btn_level_w),
  .stretch_end(stretch_end_w),
  .count      (count_w),
  .state      (state_w)
);

// File: tb/pbrst_ctrl_tb.sv
module pbrst_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int S = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic pf = 1'b0;
  logic rst_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbrst_ctrl #(.DEBOUNCE_CYCLES(D), .STRETCH_CYCLES(S)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .btn_ni    (btn_n),
    .pwr_fail_i(pf),
    .rst_no    (rst_out)
  );

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    n_checks++;
    if (rst_out !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_no actual %b expected %b at %0t", req, rst_out, exp, $time);
    end
  endtask

  task automatic test_power_on();
    adv(3);
    chk("R1 held in reset", 1'b0);
    rst_n = 1'b1;
    adv(S - 1);
    chk("R1 before window end", 1'b0);
    adv(1);
    chk("R1 released", 1'b1);
  endtask

  task automatic test_glitch();
    int lows = 0;
    btn_n = 1'b0;
    adv(D - 1);
    btn_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      adv(1);
      if (!rst_out) lows++;
    end
    n_checks++;
    if (lows != 0) begin
      n_fail++;
      $display("FAIL R11: low samples actual %0d expected 0", lows);
    end
  endtask

  task automatic test_long_press();
    btn_n = 1'b0;
    adv(D + 2);
    chk("R2 before latency", 1'b1);
    adv(1);
    chk("R2 asserted", 1'b0);
    adv(S);
    chk("R3 window", 1'b0);
    adv(40);
    chk("R4 held", 1'b0);
    btn_n = 1'b1;
    adv(D + S + 2);
    chk("R5 before release", 1'b0);
    adv(1);
    chk("R5 released", 1'b1);
    adv(10);
  endtask

  task automatic test_short_press();
    btn_n = 1'b0;
    adv(10);
    btn_n = 1'b1;
    adv(2*S + D + 3 - 10);
    chk("R6 last low cycle", 1'b0);
    adv(1);
    chk("R6 released", 1'b1);
    adv(10);
  endtask

  task automatic test_power_fail();
    pf = 1'b1;
    adv(1);
    chk("R8 asserted", 1'b0);
    adv(30);
    chk("R8 held", 1'b0);
    pf = 1'b0;
    adv(S);
    chk("R9 before release", 1'b0);
    adv(1);
    chk("R9 released", 1'b1);
    adv(10);
  endtask

  task automatic test_priority();
    btn_n = 1'b0;
    adv(D + 3 + S + 5);
    chk("R10 in hold", 1'b0);
    pf = 1'b1;
    adv(5);
    btn_n = 1'b1;
    adv(D + S + 10);
    chk("R10 button timing overridden", 1'b0);
    pf = 1'b0;
    adv(S);
    chk("R10 before release", 1'b0);
    adv(1);
    chk("R10 released", 1'b1);
    adv(10);
  endtask

  task automatic test_ignore();
    pf = 1'b1;
    adv(3);
    btn_n = 1'b0;
    adv(10);
    pf = 1'b0;
    adv(S + 1);
    chk("R7 released with button held", 1'b1);
    adv(30);
    chk("R7 no new cycle", 1'b1);
    btn_n = 1'b1;
    adv(30);
    chk("R7 quiet after release", 1'b1);
  endtask

  initial begin
    test_power_on();
    adv(5);
    test_glitch();
    test_long_press();
    test_short_press();
    test_power_fail();
    test_priority();
    test_ignore();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule